// File: doc/BRIEF.md
# Indirect Gate List Access Port

This block lets software reach the gate control list of a time-scheduled traffic shaper, and that shaper's schedule settings, through a small window of two registers. Neither the list entries nor the settings are mapped directly. Software first places the value in the data register. It then writes the command register, which carries a target address, a space selector and a start flag. The write that sets the start flag launches one internal write. The flag stays set while that write is in flight and drops when the write has been made, so software polls it.

A selector value of 0 aims the write at the list memory, which sits outside this block and is fed through a one-cycle write strobe. A selector value of 1 aims it at the schedule settings, which the block keeps itself and presents on ports to the scheduler. These settings are the schedule start time (low and high words), the period (low and high words), the time extension and the list length. A target that does not exist is dropped quietly, and the flag still clears.

Top module: `gate_list_port`

## Requirements
- R1: After reset the data register, the command register, every schedule setting, `xfer_busy`, `xfer_done` and `gl_we` are all zero.
- R2: Register offset 0 is the data register and reads back the last value written to it. Offset 1 is the command register. Offsets 2 and 3 read as zero, and writes to them have no effect.
- R3: The command word holds the start flag at bit 0, the selector at bit 1 and the target address in bits [15:8]. A command write with bit 0 clear stores the selector and address, which read back, and it launches no transfer.
- R4: A command write with bit 0 set, made while idle, launches a transfer. Bit 0 of a command read, and `xfer_busy`, then read 1 for exactly XFER_LAT (4) cycles and then return to 0.
- R5: A transfer with selector 0 and an address below LIST_DEPTH (64) raises `gl_we` for one cycle, in the cycle that busy drops. During that pulse, `gl_addr` carries the address and `gl_wdata` carries the data.
- R6: A transfer with selector 1 writes the data to a setting chosen by the address: 0 is base-time low, 1 is base-time high, 2 is cycle-time low, 3 is cycle-time high, 4 is time extension, 5 is list length. The new value shows on its port in the cycle that busy drops.
- R7: Command writes made while a transfer is in flight are ignored. They change neither the stored selector nor the stored address, and they launch no further transfer.
- R8: The data word is captured at launch. A data-register write made during the transfer does not alter the value written, but it does update the data register.
- R9: A list transfer with address LIST_DEPTH or above produces no `gl_we`, yet busy still clears after XFER_LAT cycles.
- R10: A settings transfer with address 6 or above changes no setting, yet busy still clears after XFER_LAT cycles.
- R11: `xfer_done` pulses high for exactly one cycle when a transfer completes, dropped or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset (0 data, 1 command) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| xfer_busy | output | 1 | Transfer in flight |
| xfer_done | output | 1 | One-cycle completion pulse |
| gl_we | output | 1 | List memory write strobe |
| gl_addr | output | 6 | List memory write address |
| gl_wdata | output | 32 | List memory write data |
| base_time_lo | output | 32 | Schedule start time, low word |
| base_time_hi | output | 32 | Schedule start time, high word |
| cycle_time_lo | output | 32 | Schedule period, low word |
| cycle_time_hi | output | 32 | Schedule period, high word |
| time_ext | output | 32 | Time extension |
| list_len | output | 32 | Gate list length |

## Verification
The bench targets these cases:

- **Command writes that arrive while busy.** A design that accepted them would overwrite the stored address or launch a second list write. The scoreboard would then see an entry it did not expect.
- **Data writes during a transfer.** A design that did not capture the data at launch would put the newer word into the list.
- **The last list index, and the first index past it.** These catch an off-by-one range check, which would drop a valid write or let an illegal one through.
- **Bit 0 dropping after exactly XFER_LAT cycles, and a single `xfer_done` pulse.** Any error in the latency counter shows up as a wrong busy count or a repeated pulse.

// File: rtl/glp_pkg.sv
package glp_pkg;
  // register offsets of the software window
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_CMD  = 1;

  // command word bit positions
  localparam int unsigned CMD_START_BIT = 0;
  localparam int unsigned CMD_SPACE_BIT = 1;

  // schedule setting indices in settings space
  typedef enum logic [2:0] {
    SET_BASE_LO  = 3'd0,
    SET_BASE_HI  = 3'd1,
    SET_CYCLE_LO = 3'd2,
    SET_CYCLE_HI = 3'd3,
    SET_EXT      = 3'd4,
    SET_LEN      = 3'd5
  } set_idx_e;

  localparam int unsigned NUM_SETTINGS = 6;

  typedef enum logic {
    SPACE_LIST = 1'b0,
    SPACE_SETTINGS = 1'b1
  } space_e;
endpackage

// File: rtl/glp_regs.sv
module glp_regs
  import glp_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned ADDR_SHIFT = 8,
  parameter int unsigned AW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  output logic          launch,
  output space_e        launch_space,
  output logic [AW-1:0] launch_addr,
  output logic [DW-1:0] data_q
);
  logic [DW-1:0] data_n;
  logic          data_en;
  space_e        space_q, space_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          cmd_en;
  logic          wr_data, wr_cmd;

  always_comb begin
    wr_data = reg_we && (reg_addr == 2'(OFS_DATA));
    wr_cmd  = reg_we && (reg_addr == 2'(OFS_CMD));
    data_en = wr_data;
    data_n  = reg_wdata;
    // command fields are frozen while a transfer is in flight
    cmd_en  = wr_cmd && !busy;
    space_n = space_e'(reg_wdata[CMD_SPACE_BIT]);
    addr_n  = reg_wdata[ADDR_SHIFT +: AW];
    launch  = cmd_en && reg_wdata[CMD_START_BIT];
    launch_space = space_n;
    launch_addr  = addr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      space_q <= SPACE_LIST;
      addr_q  <= '0;
    end else if (cmd_en) begin
      space_q <= space_n;
      addr_q  <= addr_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 2'(OFS_DATA)) begin
      reg_rdata = data_q;
    end else if (reg_addr == 2'(OFS_CMD)) begin
      reg_rdata[CMD_START_BIT]     = busy;
      reg_rdata[CMD_SPACE_BIT]     = space_q;
      reg_rdata[ADDR_SHIFT +: AW]  = addr_q;
    end
  end
endmodule

// File: rtl/glp_seq.sv
module glp_seq
  import glp_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned AW         = 8,
  parameter int unsigned LIST_DEPTH = 64,
  parameter int unsigned XFER_LAT   = 4,
  localparam int unsigned LIST_AW   = $clog2(LIST_DEPTH),
  localparam int unsigned CW        = (XFER_LAT > 1) ? $clog2(XFER_LAT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  space_e             launch_space,
  input  logic [AW-1:0]      launch_addr,
  input  logic [DW-1:0]      launch_data,
  output logic               busy,
  output logic               done,
  output logic               gl_we,
  output logic [LIST_AW-1:0] gl_addr,
  output logic [DW-1:0]      gl_wdata,
  output logic               set_we,
  output logic [2:0]         set_idx,
  output logic [DW-1:0]      set_data
);
  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_q, done_n;
  logic          glwe_q, glwe_n;
  space_e        cap_space_q;
  logic [AW-1:0] cap_addr_q;
  logic [DW-1:0] cap_data_q;
  logic          commit, list_ok, set_ok;

  always_comb begin
    list_ok = (cap_space_q == SPACE_LIST) && (32'(cap_addr_q) < 32'(LIST_DEPTH));
    set_ok  = (cap_space_q == SPACE_SETTINGS) && (32'(cap_addr_q) < 32'(NUM_SETTINGS));
    commit  = busy_q && (cnt_q == '0);
    busy_n  = busy_q;
    cnt_n   = cnt_q;
    done_n  = 1'b0;
    glwe_n  = 1'b0;
    if (launch) begin
      busy_n = 1'b1;
      cnt_n  = CW'(XFER_LAT - 1);
    end else if (busy_q) begin
      if (commit) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        glwe_n = list_ok;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      glwe_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
      glwe_q <= glwe_n;
    end
  end

  // operands are captured once, at launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_space_q <= SPACE_LIST;
      cap_addr_q  <= '0;
      cap_data_q  <= '0;
    end else if (launch) begin
      cap_space_q <= launch_space;
      cap_addr_q  <= launch_addr;
      cap_data_q  <= launch_data;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign gl_we    = glwe_q;
  assign gl_addr  = cap_addr_q[LIST_AW-1:0];
  assign gl_wdata = cap_data_q;
  assign set_we   = commit && set_ok;
  assign set_idx  = cap_addr_q[2:0];
  assign set_data = cap_data_q;
endmodule

// File: rtl/glp_set_bank.sv
module glp_set_bank
  import glp_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic [2:0]    set_idx,
  input  logic [DW-1:0] set_data,
  output logic [DW-1:0] set_q [NUM_SETTINGS]
);
  for (genvar i = 0; i < NUM_SETTINGS; i++) begin : g_set
    logic en;
    assign en = set_we && (set_idx == 3'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        set_q[i] <= '0;
      end else if (en) begin
        set_q[i] <= set_data;
      end
    end
  end
endmodule

// File: rtl/gate_list_port.sv
module gate_list_port
  import glp_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned ADDR_SHIFT = 8,
  parameter int unsigned AW         = 8,
  parameter int unsigned LIST_DEPTH = 64,
  parameter int unsigned XFER_LAT   = 4,
  localparam int unsigned LIST_AW   = $clog2(LIST_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               xfer_busy,
  output logic               xfer_done,
  output logic               gl_we,
  output logic [LIST_AW-1:0] gl_addr,
  output logic [DW-1:0]      gl_wdata,
  output logic [DW-1:0]      base_time_lo,
  output logic [DW-1:0]      base_time_hi,
  output logic [DW-1:0]      cycle_time_lo,
  output logic [DW-1:0]      cycle_time_hi,
  output logic [DW-1:0]      time_ext,
  output logic [DW-1:0]      list_len
);
  // reset asserts asynchronously, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic          launch;
  space_e        launch_space;
  logic [AW-1:0] launch_addr;
  logic [DW-1:0] data_q;
  logic          set_we;
  logic [2:0]    set_idx;
  logic [DW-1:0] set_data;
  logic [DW-1:0] set_q [NUM_SETTINGS];

  glp_regs #(.DW(DW), .ADDR_SHIFT(ADDR_SHIFT), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(xfer_busy),
    .launch(launch), .launch_space(launch_space),
    .launch_addr(launch_addr), .data_q(data_q)
  );

  glp_seq #(.DW(DW), .AW(AW), .LIST_DEPTH(LIST_DEPTH), .XFER_LAT(XFER_LAT)) u_seq (
    .clk(clk), .rst_n(rst_core_n),
    .launch(launch), .launch_space(launch_space),
    .launch_addr(launch_addr), .launch_data(data_q),
    .busy(xfer_busy), .done(xfer_done),
    .gl_we(gl_we), .gl_addr(gl_addr), .gl_wdata(gl_wdata),
    .set_we(set_we), .set_idx(set_idx), .set_data(set_data)
  );

  glp_set_bank #(.DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_core_n),
    .set_we(set_we), .set_idx(set_idx), .set_data(set_data),
    .set_q(set_q)
  );

  assign base_time_lo  = set_q[SET_BASE_LO];
  assign base_time_hi  = set_q[SET_BASE_HI];
  assign cycle_time_lo = set_q[SET_CYCLE_LO];
  assign cycle_time_hi = set_q[SET_CYCLE_HI];
  assign time_ext      = set_q[SET_EXT];
  assign list_len      = set_q[SET_LEN];
endmodule

// File: rtl/gate_list_port_chk.sv
module gate_list_port_chk #(
  parameter int unsigned DW       = 32,
  parameter int unsigned XFER_LAT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    reg_addr,
  input logic [DW-1:0] reg_rdata,
  input logic          xfer_busy,
  input logic          xfer_done,
  input logic          gl_we,
  input logic [DW-1:0] base_time_lo,
  input logic [DW-1:0] base_time_hi,
  input logic [DW-1:0] cycle_time_lo,
  input logic [DW-1:0] cycle_time_hi,
  input logic [DW-1:0] time_ext,
  input logic [DW-1:0] list_len
);
  logic [31:0] busy_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_cnt_q <= '0;
    else if (xfer_busy) busy_cnt_q <= busy_cnt_q + 1;
    else                busy_cnt_q <= '0;
  end

  AST_START_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata[0] == xfer_busy)); // R4

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_busy) |-> (busy_cnt_q == XFER_LAT)); // R4

  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!xfer_busy && $past(xfer_busy))); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R11

  AST_LIST_WE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    gl_we |-> xfer_done); // R5

  AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_done |-> $stable({base_time_lo, base_time_hi, cycle_time_lo,
                            cycle_time_hi, time_ext, list_len})); // R6
endmodule

bind gate_list_port gate_list_port_chk #(.DW(DW), .XFER_LAT(XFER_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .xfer_busy(xfer_busy), .xfer_done(xfer_done), .gl_we(gl_we),
  .base_time_lo(base_time_lo), .base_time_hi(base_time_hi),
  .cycle_time_lo(cycle_time_lo), .cycle_time_hi(cycle_time_hi),
  .time_ext(time_ext), .list_len(list_len)
);

// File: tb/tb_gate_list_port.sv
module tb_gate_list_port;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        xfer_busy, xfer_done, gl_we;
  logic [5:0]  gl_addr;
  logic [31:0] gl_wdata;
  logic [31:0] bt_lo, bt_hi, ct_lo, ct_hi, t_ext, l_len;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [37:0] exp_q [$];   // {addr, data}

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_list_port dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_busy(xfer_busy), .xfer_done(xfer_done),
    .gl_we(gl_we), .gl_addr(gl_addr), .gl_wdata(gl_wdata),
    .base_time_lo(bt_lo), .base_time_hi(bt_hi),
    .cycle_time_lo(ct_lo), .cycle_time_hi(ct_hi),
    .time_ext(t_ext), .list_len(l_len)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd(input bit sp, input int addr, input bit start);
    return (32'(addr & 8'hff) << 8) | (32'(sp) << 1) | 32'(start);
  endfunction

  // monitor: every list strobe must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && gl_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected gl_we", {26'd0, gl_addr, gl_wdata}, 64'd0);
      end else begin
        logic [37:0] e;
        e = exp_q.pop_front();
        chk({gl_addr, gl_wdata} == e, "R5 list entry", {26'd0, gl_addr, gl_wdata}, {26'd0, e});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      chk(1'b0, "watchdog", 64'(cycles), 64'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = 2'd1;
  endtask

  // counts cycles with bit 0 of the command register set, then checks done
  task automatic wait_done(input string req);
    int n = 0;
    logic [31:0] r;
    rd(2'd1, r);
    while (r[0]) begin
      n++;
      @(negedge clk);
      rd(2'd1, r);
      if (n > 100) break;
    end
    chk(n == LAT, {req, " R4 busy span"}, 64'(n), 64'(LAT));
    chk(xfer_done == 1'b1, {req, " R11 done pulse"}, 64'(xfer_done), 64'd1);
    @(negedge clk);
    chk(xfer_done == 1'b0, {req, " R11 done single"}, 64'(xfer_done), 64'd0);
  endtask

  task automatic xfer(input bit sp, input int addr, input logic [31:0] d, input string req);
    wr(2'd0, d);
    if (!sp && addr < DEPTH) exp_q.push_back({6'(addr), d});
    wr(2'd1, cmd(sp, addr, 1'b1));
    wait_done(req);
  endtask

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, r); chk(r == 0, "R1 data reg", 64'(r), 0);
    rd(2'd1, r); chk(r == 0, "R1 cmd reg", 64'(r), 0);
    chk(!xfer_busy && !xfer_done && !gl_we, "R1 flags", {61'd0, xfer_busy, xfer_done, gl_we}, 0);
    chk({bt_lo, bt_hi, ct_lo, ct_hi, t_ext, l_len} == '0, "R1 settings", 64'(bt_lo | l_len | t_ext), 0);

    // R2 data register and unused offsets
    wr(2'd0, 32'hA5A5_1234);
    rd(2'd0, r); chk(r == 32'hA5A5_1234, "R2 data readback", 64'(r), 64'hA5A51234);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, r); chk(r == 0, "R2 offset 2 reads zero", 64'(r), 0);
    rd(2'd0, r); chk(r == 32'hA5A5_1234, "R2 offset 2 write no effect", 64'(r), 64'hA5A51234);

    // R3 command write without start
    wr(2'd1, cmd(1'b1, 5, 1'b0));
    rd(2'd1, r); chk(r == cmd(1'b1, 5, 1'b0), "R3 fields readback", 64'(r), 64'(cmd(1'b1, 5, 1'b0)));
    repeat (LAT + 2) begin
      chk(!xfer_busy && !xfer_done, "R3 no launch", {62'd0, xfer_busy, xfer_done}, 0);
      @(negedge clk);
    end

    // R5 list writes at several addresses, including the last index
    xfer(1'b0, 3, 32'h0000_00F3, "R5 addr3");
    xfer(1'b0, 0, 32'hDEAD_BEEF, "R5 addr0");
    xfer(1'b0, DEPTH - 1, 32'h1357_9BDF, "R5 last index");
    chk(exp_q.size() == 0, "R5 scoreboard drained", 64'(exp_q.size()), 0);

    // R6 every schedule setting
    xfer(1'b1, 0, 32'h1111_0000, "R6 base lo");
    xfer(1'b1, 1, 32'h2222_0001, "R6 base hi");
    xfer(1'b1, 2, 32'h3333_0002, "R6 cycle lo");
    xfer(1'b1, 3, 32'h4444_0003, "R6 cycle hi");
    xfer(1'b1, 4, 32'h5555_0004, "R6 ext");
    xfer(1'b1, 5, 32'h0000_0008, "R6 len");
    chk(bt_lo == 32'h1111_0000, "R6 base_time_lo", 64'(bt_lo), 64'h11110000);
    chk(bt_hi == 32'h2222_0001, "R6 base_time_hi", 64'(bt_hi), 64'h22220001);
    chk(ct_lo == 32'h3333_0002, "R6 cycle_time_lo", 64'(ct_lo), 64'h33330002);
    chk(ct_hi == 32'h4444_0003, "R6 cycle_time_hi", 64'(ct_hi), 64'h44440003);
    chk(t_ext == 32'h5555_0004, "R6 time_ext", 64'(t_ext), 64'h55550004);
    chk(l_len == 32'h0000_0008, "R6 list_len", 64'(l_len), 64'h8);

    // R7 command writes during busy are ignored
    wr(2'd0, 32'h0000_7777);
    exp_q.push_back({6'd10, 32'h0000_7777});
    wr(2'd1, cmd(1'b0, 10, 1'b1));
    wr(2'd1, cmd(1'b0, 20, 1'b1));
    wr(2'd1, cmd(1'b1, 2, 1'b1));
    begin
      int n = 2;
      rd(2'd1, r);
      chk(r[15:1] == cmd(1'b0, 10, 1'b0) >> 1, "R7 fields frozen", 64'(r), 64'(cmd(1'b0, 10, 1'b1)));
      while (xfer_busy && n < 100) begin n++; @(negedge clk); end
      chk(n == LAT, "R7 R4 busy span", 64'(n), 64'(LAT));
    end
    repeat (LAT + 3) @(negedge clk);
    chk(!xfer_busy && exp_q.size() == 0, "R7 no relaunch", 64'(exp_q.size()), 0);
    chk(ct_lo == 32'h3333_0002, "R7 settings untouched", 64'(ct_lo), 64'h33330002);

    // R8 data captured at launch
    wr(2'd0, 32'hAAAA_0001);
    exp_q.push_back({6'd7, 32'hAAAA_0001});
    wr(2'd1, cmd(1'b0, 7, 1'b1));
    wr(2'd0, 32'hBBBB_0002);
    while (xfer_busy) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R8 captured entry written", 64'(exp_q.size()), 0);
    rd(2'd0, r); chk(r == 32'hBBBB_0002, "R8 data reg updated", 64'(r), 64'hBBBB0002);

    // R9 list address past the depth
    xfer(1'b0, DEPTH, 32'hCAFE_0040, "R9 addr depth");
    xfer(1'b0, 255, 32'hCAFE_00FF, "R9 addr max");
    chk(exp_q.size() == 0, "R9 no list write", 64'(exp_q.size()), 0);

    // R10 undefined settings address
    xfer(1'b1, 6, 32'hFFFF_FFFF, "R10 addr6");
    xfer(1'b1, 7, 32'hEEEE_EEEE, "R10 addr7");
    chk({bt_lo, bt_hi, ct_lo, ct_hi, t_ext, l_len} ==
        {32'h1111_0000, 32'h2222_0001, 32'h3333_0002, 32'h4444_0003, 32'h5555_0004, 32'h8},
        "R10 settings unchanged", 64'(l_len), 64'h8);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule